// File: doc/BRIEF.md
# ADC Sequence Status Tracker

This block follows the progress of conversion sequences in a multi-channel analog-to-digital converter controller. It keeps a 3-bit result-slot counter, eight per-slot done flags and one sequence-done flag, and it presents them on two read-only status bytes. The counter also drives the slot index where the result of the conversion in progress is written.

The surrounding controller sends the block four kinds of event:

- a strobe when a conversion finishes,
- a strobe when software writes the control registers to start a sequence,
- a strobe with a slot index when software reads a result register,
- static mode bits for continuous scan, FIFO-style slot counting, fast flag clearing and sequence length.

The block does not contain the analog converter, the channel multiplexing or the result storage.

Top module: `adc_seq_status`

## Requirements
- R1: `statusByte0` carries the sequence-done flag in bit 7 and the slot counter in bits 2..0, and bits 6..3 are always 0. `statusByte1` bit n is the done flag of slot n. `writeIdx` always equals the slot counter.
- R2: After reset, both status bytes and `writeIdx` are 0 and no sequence is running.
- R3: `seqStart` begins a sequence at position 0. Each `convDone` counted during a running sequence moves the slot counter up by one, and the counter wraps from 7 to 0.
- R4: When `seqLen8`=0 a sequence is 4 conversions long, and when it is 1 a sequence is 8 conversions long. The sequence-done flag is set on the last conversion of each sequence.
- R5: When `scanMode`=1, a new sequence begins at position 0 as soon as one completes. When `scanMode`=0, the sequence stops after it completes, and later `convDone` pulses change nothing until the next `seqStart`.
- R6: When `fifoMode`=0, `seqStart` resets the slot counter to 0. When `fifoMode`=1, `seqStart` leaves the counter unchanged.
- R7: The conversion at position n of a sequence sets done flag n.
- R8: When `fastClear`=0, `seqStart` clears the sequence-done flag and all eight done flags, and result reads have no effect on any flag.
- R9: When `fastClear`=1, a result read of slot n clears done flag n and the sequence-done flag. In this mode `seqStart` leaves all flags unchanged.
- R10: If a flag is set and cleared in the same cycle, it ends up set.
- R11: A `convDone` in the same cycle as `seqStart` is dropped. The new sequence still begins at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One conversion finished |
| seqStart | input | 1 | Control write that starts a sequence |
| resRead | input | 1 | A result register is being read |
| resReadIdx | input | 3 | Slot index of the result read |
| scanMode | input | 1 | Run sequences back to back |
| fifoMode | input | 1 | Keep the slot counter across sequence starts |
| fastClear | input | 1 | Clear flags on result reads instead of on starts |
| seqLen8 | input | 1 | Sequence length: 0 = 4 conversions, 1 = 8 conversions |
| statusByte0 | output | 8 | Sequence-done flag and slot counter |
| statusByte1 | output | 8 | Per-slot done flags |
| writeIdx | output | 3 | Slot that receives the current result |

## Verification
The bench targets several corner cases, each with a visible symptom if handled wrongly:

- **Counter wrap in FIFO mode across a sequence start.** A design that resets the counter here would put `writeIdx` back to 0. One that does not wrap would corrupt bits 6..3.
- **Set and clear in the same cycle.** A result read of the slot being completed in that cycle must leave the slot's flag set. A design where the clear wins would drop that flag.
- **Conversion arriving together with a start.** A design that counts this conversion would show the new sequence's first flag too early and a shifted counter.
- **Stray conversions after a non-scan sequence has ended.** A design that keeps counting would go on moving `writeIdx`.
- **Reads while fast clear is off, and starts while it is on.** A design that mixes up the two clear modes would lose flags when it should keep them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int NUM_SLOTS = 8;
  parameter int SHORT_LEN = 4;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic                 restartCnt;
    logic                 advCnt;
    logic                 setScf;
    logic                 clrScf;
    logic [NUM_SLOTS-1:0] setCcf;
    logic [NUM_SLOTS-1:0] clrCcf;
  } seq_strobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              seqStart,
  input  logic              resRead,
  input  logic [SLOT_W-1:0] resReadIdx,
  input  logic              scanMode,
  input  logic              fifoMode,
  input  logic              fastClear,
  input  logic              seqLen8,
  output seq_strobe_t       strb,
  output logic              seqActive
);
  localparam logic [SLOT_W-1:0] LAST_LONG  = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAST_SHORT = SLOT_W'(SHORT_LEN - 1);

  logic [SLOT_W-1:0] seqPos;
  logic [SLOT_W-1:0] lastPos;
  logic              countIt;
  logic              lastConv;
  logic              startClr;
  logic              readClr;

  assign lastPos  = seqLen8 ? LAST_LONG : LAST_SHORT;
  assign countIt  = convDone && seqActive && !seqStart;
  assign lastConv = countIt && (seqPos == lastPos);
  assign startClr = seqStart && !fastClear;
  assign readClr  = resRead && fastClear;

  always_comb begin
    strb            = '0;
    strb.restartCnt = seqStart && !fifoMode;
    strb.advCnt     = countIt;
    strb.setScf     = lastConv;
    strb.clrScf     = startClr || readClr;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      strb.setCcf[i] = countIt && (seqPos == SLOT_W'(i));
      strb.clrCcf[i] = startClr || (readClr && (resReadIdx == SLOT_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqActive <= 1'b0;
      seqPos    <= '0;
    end else if (seqStart) begin
      seqActive <= 1'b1;
      seqPos    <= '0;
    end else if (countIt) begin
      if (lastConv) begin
        seqPos    <= '0;
        seqActive <= scanMode;
      end else begin
        seqPos <= seqPos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          strb,
  output logic [SLOT_W-1:0]    slotCnt,
  output logic                 scf,
  output logic [NUM_SLOTS-1:0] ccf
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (strb.restartCnt) begin
      slotCnt <= '0;
    end else if (strb.advCnt) begin
      slotCnt <= (slotCnt == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slotCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) scf <= 1'b0;
    else       scf <= strb.setScf || (scf && !strb.clrScf);
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) ccf[g] <= 1'b0;
      else       ccf[g] <= strb.setCcf[g] || (ccf[g] && !strb.clrCcf[g]);
    end
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              seqStart,
  input  logic              resRead,
  input  logic [SLOT_W-1:0] resReadIdx,
  input  logic              scanMode,
  input  logic              fifoMode,
  input  logic              fastClear,
  input  logic              seqLen8,
  output logic [7:0]        statusByte0,
  output logic [NUM_SLOTS-1:0] statusByte1,
  output logic [SLOT_W-1:0] writeIdx
);
  seq_strobe_t          strb;
  logic                 seqActive;
  logic [SLOT_W-1:0]    slotCnt;
  logic                 scf;
  logic [NUM_SLOTS-1:0] ccf;

  adc_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .convDone(convDone), .seqStart(seqStart),
    .resRead(resRead), .resReadIdx(resReadIdx), .scanMode(scanMode),
    .fifoMode(fifoMode), .fastClear(fastClear), .seqLen8(seqLen8),
    .strb(strb), .seqActive(seqActive)
  );

  adc_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .slotCnt(slotCnt), .scf(scf), .ccf(ccf)
  );

  always_comb begin
    statusByte0 = '0;
    statusByte0[7] = scf;
    statusByte0[SLOT_W-1:0] = slotCnt;
  end
  assign statusByte1 = ccf;
  assign writeIdx    = slotCnt;
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       convDone,
  input logic       seqStart,
  input logic       resRead,
  input logic [2:0] resReadIdx,
  input logic       fifoMode,
  input logic       fastClear,
  input logic       seqActive,
  input logic [7:0] statusByte0,
  input logic [7:0] statusByte1,
  input logic [2:0] writeIdx
);
  a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    statusByte0[6:3] == 4'd0 && statusByte0[2:0] == writeIdx);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rstN)
    convDone && seqActive && !seqStart |=> writeIdx == $past(writeIdx) + 3'd1);

  a_r5_idle_ignore: assert property (@(posedge clk) disable iff (!rstN)
    convDone && !seqActive && !seqStart |=> $stable(writeIdx));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    seqStart && !fifoMode |=> writeIdx == 3'd0);

  a_r6_fifo_hold: assert property (@(posedge clk) disable iff (!rstN)
    seqStart && fifoMode |=> $stable(writeIdx));

  a_r8_start_clear: assert property (@(posedge clk) disable iff (!rstN)
    seqStart && !fastClear |=> statusByte1 == 8'd0 && !statusByte0[7]);

  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    resRead && fastClear && !convDone |=> !statusByte1[$past(resReadIdx)] && !statusByte0[7]);
endmodule

bind adc_seq_status adc_seq_status_chk chk_i (
  .clk(clk), .rstN(rstN), .convDone(convDone), .seqStart(seqStart),
  .resRead(resRead), .resReadIdx(resReadIdx), .fifoMode(fifoMode),
  .fastClear(fastClear), .seqActive(seqActive), .statusByte0(statusByte0),
  .statusByte1(statusByte1), .writeIdx(writeIdx)
);

// File: tb/adc_seq_status_tb_top.sv
module adc_seq_status_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 0, seqStart = 0, resRead = 0;
  logic [2:0] resReadIdx = '0;
  logic scanMode = 0, fifoMode = 0, fastClear = 0, seqLen8 = 0;
  logic [7:0] statusByte0, statusByte1;
  logic [2:0] writeIdx;

  int checks = 0;
  int failures = 0;

  // Bench model built from the requirements
  logic       mActive;
  logic [2:0] mPos, mCc;
  logic       mScf;
  logic [7:0] mCcf;

  always #2.5 clk = ~clk;

  adc_seq_status dut_i (
    .clk(clk), .rstN(rstN), .convDone(convDone), .seqStart(seqStart),
    .resRead(resRead), .resReadIdx(resReadIdx), .scanMode(scanMode),
    .fifoMode(fifoMode), .fastClear(fastClear), .seqLen8(seqLen8),
    .statusByte0(statusByte0), .statusByte1(statusByte1), .writeIdx(writeIdx)
  );

  function automatic logic [7:0] expByte0();
    return {mScf, 4'b0000, mCc};
  endfunction

  task automatic modelReset();
    mActive = 0; mPos = 0; mCc = 0; mScf = 0; mCcf = 0;
  endtask

  task automatic modelStep();
    logic [7:0] setMask;
    logic       setScf;
    setMask = 0;
    setScf  = 0;
    if (seqStart) begin
      mActive = 1;
      mPos    = 0;
      if (!fifoMode) mCc = 0;
    end else if (convDone && mActive) begin
      setMask[mPos] = 1'b1;
      mCc = mCc + 3'd1;
      if (mPos == (seqLen8 ? 3'd7 : 3'd3)) begin
        setScf  = 1;
        mPos    = 0;
        mActive = scanMode;
      end else begin
        mPos = mPos + 3'd1;
      end
    end
    if (seqStart && !fastClear) begin
      mScf = 0; mCcf = 0;
    end
    if (resRead && fastClear) begin
      mScf = 0; mCcf[resReadIdx] = 1'b0;
    end
    mScf = mScf | setScf;
    mCcf = mCcf | setMask;
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    checkVal({tag, " R1 byte0"}, statusByte0, expByte0());
    checkVal({tag, " R7 byte1"}, statusByte1, mCcf);
    checkVal({tag, " R3 writeIdx"}, writeIdx, mCc);
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic doCycle(logic cd, logic ss, logic rr, logic [2:0] idx);
    convDone = cd; seqStart = ss; resRead = rr; resReadIdx = idx;
    step();
    convDone = 0; seqStart = 0; resRead = 0; resReadIdx = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkVal("R2 reset byte0", statusByte0, 0);
    checkVal("R2 reset byte1", statusByte1, 0);
    checkVal("R2 reset writeIdx", writeIdx, 0);

    // short non-scan sequence
    doCycle(0, 1, 0, 0);
    repeat (4) doCycle(1, 0, 0, 0);
    checkVal("R4 short sequence byte0", statusByte0, 8'h84);
    checkVal("R7 short sequence byte1", statusByte1, 8'h0F);
    doCycle(1, 0, 0, 0);
    checkVal("R5 done ignored when stopped", writeIdx, 4);
    doCycle(0, 0, 1, 3);
    checkVal("R8 read has no effect", statusByte1, 8'h0F);
    doCycle(0, 1, 0, 0);
    checkVal("R8 start clears byte0", statusByte0, 8'h00);
    checkVal("R8 start clears byte1", statusByte1, 8'h00);

    // FIFO counting and wrap
    fifoMode = 1; seqLen8 = 1;
    repeat (3) doCycle(1, 0, 0, 0);
    doCycle(0, 1, 0, 0);
    checkVal("R6 FIFO keeps counter", writeIdx, 3);
    repeat (8) doCycle(1, 0, 0, 0);
    checkVal("R3 counter wrapped", writeIdx, 3);
    checkVal("R4 long sequence done", statusByte0[7], 1);
    checkVal("R7 all flags", statusByte1, 8'hFF);

    // fast clear
    fastClear = 1;
    doCycle(0, 0, 1, 2);
    checkVal("R9 read clears slot", statusByte1, 8'hFB);
    checkVal("R9 read clears seq flag", statusByte0[7], 0);
    doCycle(0, 1, 0, 0);
    checkVal("R9 start keeps flags", statusByte1, 8'hFB);
    repeat (2) doCycle(1, 0, 0, 0);
    doCycle(1, 0, 1, 2);
    checkVal("R10 set beats clear", statusByte1, 8'hFF);

    // start with coincident done
    fifoMode = 0;
    doCycle(1, 1, 0, 0);
    checkVal("R11 done dropped counter", writeIdx, 0);
    doCycle(0, 0, 1, 0);
    checkVal("R11 slot0 cleared", statusByte1, 8'hFE);
    doCycle(1, 0, 0, 0);
    checkVal("R11 first position is 0", statusByte1, 8'hFF);
    checkModel("directed");

    // scan mode: back to back sequences
    scanMode = 1; seqLen8 = 0; fastClear = 0;
    doCycle(0, 1, 0, 0);
    repeat (6) doCycle(1, 0, 0, 0);
    checkVal("R5 scan continues", writeIdx, 6);
    checkVal("R5 scan flags", statusByte1, 8'h0F);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 40) == 0) begin
        scanMode  = 1'($urandom_range(0, 1));
        fifoMode  = 1'($urandom_range(0, 1));
        fastClear = 1'($urandom_range(0, 1));
        seqLen8   = 1'($urandom_range(0, 1));
      end
      convDone   = ($urandom_range(0, 1) == 1);
      seqStart   = ($urandom_range(0, 11) == 0);
      resRead    = ($urandom_range(0, 3) == 0);
      resReadIdx = 3'($urandom_range(0, 7));
      step();
      checkModel("random");
    end
    convDone = 0; seqStart = 0; resRead = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule